// File: doc/BRIEF.md
# Watchdog Timer with Read-Clear Status

This block is a down-counting watchdog for a small microcontroller. When the enable input goes high, the counter is loaded from a reload value held in byte-wide registers on a simple register bus. After that it counts down once for every cycle in which the low-rate tick enable is high. A refresh strobe from the CPU loads the counter again. If the counter is allowed to expire, the block raises either an interrupt pulse or a reset-request pulse. A static configuration input selects which one.

A status byte records that a time-out happened. In interrupt mode it also records that the time-out arrived while the system was in stop mode. In that case a stop-mode recovery pulse is issued alongside the interrupt. Reading the status byte clears it. Power-on reset is the only other way to clear it, so the flag survives a watchdog-requested reset. While the debug input is high, the counter is reloaded on every cycle and cannot expire. In interrupt mode, after a time-out the counter wraps to all-ones and keeps counting without reloading.

Top module: `wdog_timer`

## Requirements
- R1: After power-on reset, the status byte (address 0) reads 0x00, no pulse output is high, and the reload bytes read back the RELOAD_INIT parameter value.
- R2: The rising of `wd_en` loads the counter from the reload value on the next clock edge. With reload N and `tick_en` held high, the time-out pulse is visible in the cycle after the (N+1)-th tick edge that follows the load.
- R3: A `refresh` loads the counter with the reload value. A refresh in the same cycle as an expiry wins, and no pulse is produced for that expiry. After a wrap, only a refresh brings the counter back to the reload value.
- R4: While `debug_mode` is high, the counter is reloaded every cycle and no time-out pulse occurs. On release, counting starts from the reload value.
- R5: With `cfg_rst_mode`=0, a time-out gives a one-cycle `irq` pulse and sets status bit 0. The counter then wraps to all-ones and does not expire again within the next 2^CNT_W-1 ticks.
- R6: With `cfg_rst_mode`=1, a time-out gives a one-cycle `rst_req` pulse with no `irq` and no `stop_rec`. It sets status bit 0 and leaves status bit 1 at 0.
- R7: A time-out with `cfg_rst_mode`=0 while `stop_mode` is high also gives a one-cycle `stop_rec` pulse together with `irq`, and sets status bits 0 and 1.
- R8: A read of address 0 returns {0, stop bit (bit 1), time-out bit (bit 0)} and clears both bits at that clock edge. A time-out in the same cycle as that read leaves the bits set.
- R9: Addresses 1, 2 and 3 hold the reload value's upper, middle and low bytes and read back what was written. A write while the counter is running changes nothing until the next load.
- R10: The counter only advances in cycles where `tick_en` is high. With `tick_en` low, no time-out occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| wd_en | input | 1 | Watchdog enable; the counter is loaded on the first cycle it is high |
| tick_en | input | 1 | Always-on low-rate count enable |
| refresh | input | 1 | CPU refresh strobe |
| debug_mode | input | 1 | Holds the counter in constant refresh |
| stop_mode | input | 1 | System is in stop mode |
| cfg_rst_mode | input | 1 | Static response select: 0 interrupt, 1 reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | ADDR_W (2) | Register address |
| bus_wdata | input | DATA_W (8) | Write data |
| bus_rdata | output | DATA_W (8) | Read data, combinational |
| irq | output | 1 | One-cycle time-out interrupt request |
| rst_req | output | 1 | One-cycle system reset request |
| stop_rec | output | 1 | One-cycle stop-mode recovery request |

## Verification
Two pairs of events can fall in the same cycle. The first is an expiry and a refresh. The bench counts ticks from the load and raises `refresh` in exactly the cycle the counter sits at zero with a tick pending. It then judges that no pulse appears and that the next pulse comes a full reload period later. The second is an expiry and a status read. The bench starts a read of address 0 in the expiry cycle and expects the read data to show the old flags, while a second read shows the time-out bit still set.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   // Status byte bit positions
   localparam int unsigned ST_TO_BIT   = 0;
   localparam int unsigned ST_STOP_BIT = 1;
   // Address of the status byte; reload bytes follow, most significant first
   localparam int unsigned STATUS_ADDR = 0;

   typedef enum logic {
      RESP_IRQ   = 1'b0,
      RESP_RESET = 1'b1
   } resp_e;
endpackage

// File: rtl/wdog_reload_regs.sv
module wdog_reload_regs #(
   parameter int unsigned CNT_W  = 24,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 2,
   parameter logic [CNT_W-1:0] RELOAD_INIT = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [CNT_W-1:0]  reload,
   output logic [DATA_W-1:0] rd_byte
);
   localparam int unsigned NB = CNT_W / DATA_W;

   for (genvar i = 0; i < NB; i++) begin : g_byte
      localparam int unsigned HI = CNT_W - 1 - i * DATA_W;
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= RELOAD_INIT[HI -: DATA_W];
         else if (wr_en && addr == ADDR_W'(i + 1))
            q <= wdata;
      end
      assign reload[HI -: DATA_W] = q;
   end

   always_comb begin
      rd_byte = '0;
      for (int i = 0; i < NB; i++) begin
         if (addr == ADDR_W'(i + 1))
            rd_byte = reload[CNT_W - 1 - i * DATA_W -: DATA_W];
      end
   end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
   parameter int unsigned CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic             tick_en,
   input  logic             refresh,
   input  logic             debug_mode,
   input  logic [CNT_W-1:0] reload,
   output logic             expire,
   output logic [CNT_W-1:0] cnt
);
   logic armed_q;

   // Expiry: counter sits at zero and a tick arrives with no reload pending
   assign expire = run_en && armed_q && !refresh && !debug_mode &&
                   tick_en && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         armed_q <= 1'b0;
      end else if (!run_en) begin
         armed_q <= 1'b0;
      end else if (!armed_q) begin
         cnt     <= reload;
         armed_q <= 1'b1;
      end else if (refresh || debug_mode) begin
         cnt <= reload;
      end else if (tick_en) begin
         cnt <= cnt - 1'b1;   // zero wraps to all-ones
      end
   end
endmodule

// File: rtl/wdog_status.sv
module wdog_status (
   input  logic clk,
   input  logic rst_n,
   input  logic expire,
   input  logic rst_mode,
   input  logic stop_mode,
   input  logic rd_clr,
   output logic irq,
   output logic rst_req,
   output logic stop_rec,
   output logic to_flag,
   output logic stop_flag
);
   logic irq_evt, stop_evt;
   assign irq_evt  = expire && !rst_mode;
   assign stop_evt = irq_evt && stop_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq       <= 1'b0;
         rst_req   <= 1'b0;
         stop_rec  <= 1'b0;
         to_flag   <= 1'b0;
         stop_flag <= 1'b0;
      end else begin
         irq      <= irq_evt;
         rst_req  <= expire && rst_mode;
         stop_rec <= stop_evt;
         // a new event outranks a clearing read in the same cycle
         if (expire)      to_flag <= 1'b1;
         else if (rd_clr) to_flag <= 1'b0;
         if (stop_evt)    stop_flag <= 1'b1;
         else if (rd_clr) stop_flag <= 1'b0;
      end
   end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
   import wdog_pkg::*;
#(
   parameter int unsigned CNT_W  = 24,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 2,
   parameter logic [CNT_W-1:0] RELOAD_INIT = 24'h0F4240
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wd_en,
   input  logic              tick_en,
   input  logic              refresh,
   input  logic              debug_mode,
   input  logic              stop_mode,
   input  logic              cfg_rst_mode,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq,
   output logic              rst_req,
   output logic              stop_rec
);
   localparam int unsigned NB = CNT_W / DATA_W;

   if (CNT_W % DATA_W != 0) begin : g_bad_width
      $error("CNT_W must be a multiple of DATA_W");
   end
   if ((1 << ADDR_W) < NB + 1) begin : g_bad_addr
      $error("ADDR_W too small for status plus reload bytes");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("DATA_W must hold two status bits");
   end

   logic [CNT_W-1:0]  reload, cnt_q;
   logic [DATA_W-1:0] reload_byte, status_byte;
   logic              to_evt, to_flag_q, stop_flag_q, stat_rd, reg_wr;
   resp_e             resp;

   assign resp    = resp_e'(cfg_rst_mode);
   assign reg_wr  = bus_sel && bus_wr;
   assign stat_rd = bus_sel && !bus_wr && bus_addr == ADDR_W'(STATUS_ADDR);

   wdog_reload_regs #(
      .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RELOAD_INIT(RELOAD_INIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(bus_addr),
      .wdata(bus_wdata), .reload(reload), .rd_byte(reload_byte)
   );

   wdog_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run_en(wd_en), .tick_en(tick_en),
      .refresh(refresh), .debug_mode(debug_mode), .reload(reload),
      .expire(to_evt), .cnt(cnt_q)
   );

   wdog_status u_stat (
      .clk(clk), .rst_n(rst_n), .expire(to_evt),
      .rst_mode(resp == RESP_RESET), .stop_mode(stop_mode), .rd_clr(stat_rd),
      .irq(irq), .rst_req(rst_req), .stop_rec(stop_rec),
      .to_flag(to_flag_q), .stop_flag(stop_flag_q)
   );

   always_comb begin
      status_byte = '0;
      status_byte[ST_TO_BIT]   = to_flag_q;
      status_byte[ST_STOP_BIT] = stop_flag_q;
   end

   always_comb begin
      if (!bus_sel || bus_wr)
         bus_rdata = '0;
      else if (bus_addr == ADDR_W'(STATUS_ADDR))
         bus_rdata = status_byte;
      else
         bus_rdata = reload_byte;
   end
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
   parameter int unsigned CNT_W = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run_en,
   input logic             debug_mode,
   input logic             irq,
   input logic             rst_req,
   input logic             stop_rec,
   input logic             to_flag,
   input logic             stop_flag,
   input logic             expire,
   input logic             rd_clr,
   input logic [CNT_W-1:0] cnt
);
   // R4: debug hold keeps both responses quiet
   p_debug_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (debug_mode && run_en) |=> !(irq || rst_req));

   // R5: interrupt is a single-cycle pulse
   p_irq_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   // R5: interrupt pulse comes with the time-out status bit
   p_irq_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> to_flag);

   // R5: counter has wrapped to all-ones when a response pulse shows
   p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq || rst_req) |-> (cnt == {CNT_W{1'b1}}));

   // R6: reset response excludes interrupt and recovery
   p_rst_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> (!irq && !stop_rec && to_flag));

   // R7: recovery pulse rides with interrupt and both flags
   p_stop_rec_r7: assert property (@(posedge clk) disable iff (!rst_n)
      stop_rec |-> (irq && stop_flag && to_flag));

   // R8: status read with no concurrent expiry clears the flags
   p_rd_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && !expire) |=> (!to_flag && !stop_flag));
endmodule

bind wdog_timer wdog_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .run_en(wd_en), .debug_mode(debug_mode),
   .irq(irq), .rst_req(rst_req), .stop_rec(stop_rec),
   .to_flag(to_flag_q), .stop_flag(stop_flag_q),
   .expire(to_evt), .rd_clr(stat_rd), .cnt(cnt_q)
);

// File: tb/wdog_timer_test.sv
module wdog_timer_test;
   localparam int unsigned CNT_W = 24;
   localparam int unsigned DATA_W = 8;
   localparam int unsigned ADDR_W = 2;
   localparam logic [CNT_W-1:0] RL_INIT = 24'h0F4240;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wd_en = 1'b0, tick_en = 1'b1, refresh = 1'b0, debug_mode = 1'b0;
   logic stop_mode = 1'b0, cfg_rst_mode = 1'b0;
   logic bus_sel = 1'b0, bus_wr = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [DATA_W-1:0] bus_wdata = '0;
   logic [DATA_W-1:0] bus_rdata;
   logic irq, rst_req, stop_rec;

   int checks = 0;
   int fails = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   wdog_timer #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
                .RELOAD_INIT(RL_INIT)) uut (
      .clk(clk), .rst_n(rst_n), .wd_en(wd_en), .tick_en(tick_en),
      .refresh(refresh), .debug_mode(debug_mode), .stop_mode(stop_mode),
      .cfg_rst_mode(cfg_rst_mode), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq), .rst_req(rst_req), .stop_rec(stop_rec)
   );

   typedef struct packed {
      logic [23:0] rl;
      logic        rmode;
      logic        stop;
      logic [7:0]  stat;
   } vec_t;

   localparam vec_t VECS [5] = '{
      '{rl: 24'd5,  rmode: 1'b0, stop: 1'b0, stat: 8'h01},
      '{rl: 24'd0,  rmode: 1'b0, stop: 1'b0, stat: 8'h01},
      '{rl: 24'd12, rmode: 1'b1, stop: 1'b0, stat: 8'h01},
      '{rl: 24'd7,  rmode: 1'b0, stop: 1'b1, stat: 8'h03},
      '{rl: 24'd3,  rmode: 1'b1, stop: 1'b1, stat: 8'h01}
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr_reg(input int a, input int d);
      bus_sel = 1'b1; bus_wr = 1'b1;
      bus_addr = ADDR_W'(a); bus_wdata = DATA_W'(d);
      step();
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd_reg(input int a, output int d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = ADDR_W'(a);
      #1 d = int'(bus_rdata);
      step();
      bus_sel = 1'b0;
   endtask

   task automatic set_reload(input logic [23:0] v);
      wr_reg(1, int'(v[23:16]));
      wr_reg(2, int'(v[15:8]));
      wr_reg(3, int'(v[7:0]));
   endtask

   // Steps up to limit cycles; reports first cycle each pulse was seen and pulse counts
   task automatic run(input int limit, output int k_irq, output int k_rst,
                      output int n_irq, output int n_stop);
      k_irq = 0; k_rst = 0; n_irq = 0; n_stop = 0;
      for (int k = 1; k <= limit; k++) begin
         step();
         if (irq) begin n_irq++; if (k_irq == 0) k_irq = k; end
         if (rst_req && k_rst == 0) k_rst = k;
         if (stop_rec) n_stop++;
      end
   endtask

   initial begin
      #(4 * 150000);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int d, ki, kr, ni, ns;
      repeat (3) step();
      rst_n = 1'b1;
      step();

      // R1 reset state
      check(!irq && !rst_req && !stop_rec, "R1 pulses idle", int'({irq, rst_req, stop_rec}), 0);
      rd_reg(0, d); check(d == 0, "R1 status", d, 0);
      rd_reg(1, d); check(d == int'(RL_INIT[23:16]), "R1 reload upper", d, int'(RL_INIT[23:16]));
      rd_reg(2, d); check(d == int'(RL_INIT[15:8]),  "R1 reload high",  d, int'(RL_INIT[15:8]));
      rd_reg(3, d); check(d == int'(RL_INIT[7:0]),   "R1 reload low",   d, int'(RL_INIT[7:0]));

      // Vector table: R2, R5, R6, R7, R8
      foreach (VECS[i]) begin
         wd_en = 1'b0;
         cfg_rst_mode = VECS[i].rmode;
         stop_mode = VECS[i].stop;
         set_reload(VECS[i].rl);
         rd_reg(0, d);
         wd_en = 1'b1;
         run(int'(VECS[i].rl) + 8, ki, kr, ni, ns);
         if (VECS[i].rmode) begin
            check(kr == int'(VECS[i].rl) + 2, "R6 rst_req timing", kr, int'(VECS[i].rl) + 2);
            check(ni == 0 && ns == 0, "R6 no irq/stop_rec", ni + ns, 0);
         end else begin
            check(ki == int'(VECS[i].rl) + 2, "R2 irq timing", ki, int'(VECS[i].rl) + 2);
            check(ni == 1, "R5 single irq, no re-expiry after wrap", ni, 1);
            check(kr == 0, "R5 no rst_req", kr, 0);
            check(ns == (VECS[i].stop ? 1 : 0), "R7 stop_rec count", ns, VECS[i].stop ? 1 : 0);
         end
         rd_reg(0, d);
         check(d == int'(VECS[i].stat), "R8 status value (R5/R6/R7 bits)", d, int'(VECS[i].stat));
         rd_reg(0, d);
         check(d == 0, "R8 cleared by read", d, 0);
      end
      wd_en = 1'b0; stop_mode = 1'b0; cfg_rst_mode = 1'b0;
      step();

      // R10 tick gating
      set_reload(24'd4);
      tick_en = 1'b0;
      wd_en = 1'b1;
      run(30, ki, kr, ni, ns);
      check(ni == 0, "R10 no expiry without ticks", ni, 0);
      tick_en = 1'b1;
      run(10, ki, kr, ni, ns);
      check(ki == 5, "R10 expiry after ticks resume", ki, 5);
      // R3 after wrap: nothing until refresh
      run(40, ki, kr, ni, ns);
      check(ni == 0, "R3 no auto reload after wrap", ni, 0);
      refresh = 1'b1; step(); refresh = 1'b0;
      run(10, ki, kr, ni, ns);
      check(ki == 5, "R3 refresh after wrap", ki, 5);
      wd_en = 1'b0; step(); rd_reg(0, d);

      // R3 refresh in the expiry cycle
      set_reload(24'd6);
      wd_en = 1'b1;
      run(7, ki, kr, ni, ns);
      check(ni == 0, "R3 no early expiry", ni, 0);
      refresh = 1'b1; step(); refresh = 1'b0;
      check(!irq, "R3 refresh beats expiry", int'(irq), 0);
      run(12, ki, kr, ni, ns);
      check(ki == 7, "R3 period after refresh", ki, 7);
      wd_en = 1'b0; step(); rd_reg(0, d);

      // R4 debug hold
      set_reload(24'd3);
      debug_mode = 1'b1;
      wd_en = 1'b1;
      run(40, ki, kr, ni, ns);
      check(ni == 0, "R4 no expiry in debug", ni, 0);
      debug_mode = 1'b0;
      run(10, ki, kr, ni, ns);
      check(ki == 4, "R4 count from reload on release", ki, 4);
      wd_en = 1'b0; step(); rd_reg(0, d);

      // R9 write while running takes effect at next load
      set_reload(24'd20);
      wd_en = 1'b1;
      run(5, ki, kr, ni, ns);
      set_reload(24'd3);
      rd_reg(3, d);
      check(d == 3, "R9 readback low byte", d, 3);
      run(30, ki, kr, ni, ns);
      check(ki == 13, "R9 old reload still counting", ki, 13);
      refresh = 1'b1; step(); refresh = 1'b0;
      run(10, ki, kr, ni, ns);
      check(ki == 4, "R9 new reload after refresh", ki, 4);
      wd_en = 1'b0; step(); rd_reg(0, d);

      // R8 read in the expiry cycle: flags stay set
      set_reload(24'd2);
      wd_en = 1'b1;
      run(3, ki, kr, ni, ns);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = '0;
      #1 d = int'(bus_rdata);
      check(d == 0, "R8 old flags on read", d, 0);
      step();
      bus_sel = 1'b0;
      check(irq == 1'b1, "R8 expiry in read cycle", int'(irq), 1);
      rd_reg(0, d);
      check(d == 1, "R8 set wins over clear", d, 1);
      wd_en = 1'b0; step();

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule